// File: doc/BRIEF.md
# Packetised Control Register Bank

This block is a bank of control registers that a host reaches over a byte-wide link running in both directions. The host sends a 32-bit setup packet as four bytes. The block collects the bytes and splits the packet into a 4-bit command, a 12-bit address and a 16-bit data field. It then either updates a register or sends back a 32-bit reply packet holding the requested register contents. Reads and writes use the same packet layout.

Each address can mean one thing when written and another when read. One writable board control word shares its address with a read-only firmware version word. Two further addresses return a live clock readback value and a board status value. A window of 25 writable clock registers reads back the locally held copy of each register. The host can drop a half-received packet with a framing abort input.

Both byte streams use valid/ready handshakes. On the inbound side a byte moves when `rx_valid_i` and `rx_ready_o` are both high. `rx_ready_o` falls in the cycle after a packet completes, and it stays low while a reply is still going out. On the outbound side a byte moves when `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, the block holds both `tx_valid_o` and `tx_byte_o` steady.

Top module: `pkt_regbank`

## Requirements
- R1: After a synchronous reset the board control word and every clock register are zero, `tx_valid_o` is low and `rx_ready_o` is high.
- R2: Packet bytes arrive low byte first: data[7:0], then data[15:8], then address[7:0], then {command[3:0], address[11:8]}.
- R3: A packet with command 0x1 (write) and address 0x001 loads its data field into `board_ctrl_o`. The new value is visible two cycles after the last byte is accepted.
- R4: A write to address 0x010+k, with k from 0 to 24, loads clock register k. The register appears on `clk_regs_o[16k+15:16k]`.
- R5: Only command 0x2 (read) produces a reply. The reply is {0x2, the address as sent, the register contents}, sent low byte first in the same byte order as R2. `tx_valid_o` rises in the cycle after the packet is taken.
- R6: A read of 0x001 returns the firmware version parameter. A read of 0x002 returns `clk_rb_i`, a read of 0x003 returns `status_i`, and a read of 0x010..0x028 returns the held clock register.
- R7: All 12 address bits are decoded. A read of any other address (for example 0x000, 0x029, 0x110 or 0xFFF) returns 0x0000. A write to any address except 0x001 and 0x010..0x028 changes no register.
- R8: A packet with any command other than 0x1 or 0x2 changes no register and produces no reply.
- R9: While `abort_i` is high, any partly received packet is discarded, and the next accepted byte is treated as byte 0. Abort wins over a byte offered in the same cycle.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_byte_o` hold their values. While a reply is outstanding, `rx_ready_o` is low and offered inbound bytes are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abort_i | input | 1 | Framing abort; discards a partial packet |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_ready_o | output | 1 | Inbound byte ready |
| rx_byte_i | input | 8 | Inbound byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_ready_i | input | 1 | Reply byte ready |
| tx_byte_o | output | 8 | Reply byte |
| clk_rb_i | input | 16 | Clock readback value, read at 0x002 |
| status_i | input | 16 | Board status value, read at 0x003 |
| board_ctrl_o | output | 16 | Board control register |
| clk_regs_o | output | 400 | Clock registers 0..24, 16 bits each, register k at bits 16k+15:16k |

## Verification
The hardest case to reach is a stalled reply while the host keeps offering inbound bytes. Those bytes must be refused, and packet alignment must survive afterwards. The bench holds `tx_ready_i` low through a read, drives a junk byte the whole time, and then checks two things: the held reply byte, and that the next full write lands at the right register. Abort is exercised after two and after three bytes of a packet. A sweep that writes and then reads every address from 0x000 to 0x02F, plus aliases with high address bits set, covers each decode boundary against a bench model.

// File: rtl/pktreg_pkg.sv
package pktreg_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int PKT_W  = CMD_W + ADDR_W + DATA_W;
  localparam int PKT_BYTES = PKT_W / BYTE_W;

  localparam logic [CMD_W-1:0] CMD_WRITE = 4'h1;
  localparam logic [CMD_W-1:0] CMD_READ  = 4'h2;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 12'h001;
  localparam logic [ADDR_W-1:0] ADR_CLK_RB   = 12'h002;
  localparam logic [ADDR_W-1:0] ADR_STATUS   = 12'h003;
  localparam logic [ADDR_W-1:0] ADR_CLK_BASE = 12'h010;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/pkt_collector.sv
module pkt_collector
  import pktreg_pkg::*;
#(
  parameter int BYTES = PKT_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              pkt_vld,
  output pkt_t              pkt
);
  localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

  logic [CW-1:0]             cnt;
  logic [BYTES*BYTE_W-1:0]   acc;
  logic                      take;

  assign take = in_valid && in_ready && !abort_i;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      cnt     <= '0;
      pkt_vld <= 1'b0;
    end else begin
      pkt_vld <= take && (cnt == LAST);
      if (take) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // byte k lands at bits 8k+7:8k, so byte 0 is the low data byte
  always_ff @(posedge clk) begin
    if (take) acc[cnt*BYTE_W +: BYTE_W] <= in_byte;
  end

  assign pkt = pkt_t'(acc);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import pktreg_pkg::*;
#(
  parameter int              NUM_CLK    = 25,
  parameter logic [DATA_W-1:0] FW_VERSION = 16'h0107
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pkt_vld,
  input  pkt_t                      pkt,
  input  logic [DATA_W-1:0]         clk_rb_i,
  input  logic [DATA_W-1:0]         status_i,
  output logic [DATA_W-1:0]         board_ctrl_o,
  output logic [NUM_CLK*DATA_W-1:0] clk_regs_o,
  output logic [DATA_W-1:0]         rd_data
);
  logic              wr_en;
  logic [DATA_W-1:0] clk_q [NUM_CLK];

  assign wr_en = pkt_vld && (pkt.cmd == CMD_WRITE);

  always_ff @(posedge clk) begin
    if (rst) board_ctrl_o <= '0;
    else if (wr_en && pkt.addr == ADR_CTRL) board_ctrl_o <= pkt.data;
  end

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_CLK_BASE + ADDR_W'(k);
    always_ff @(posedge clk) begin
      if (rst) clk_q[k] <= '0;
      else if (wr_en && pkt.addr == MY_ADR) clk_q[k] <= pkt.data;
    end
    assign clk_regs_o[k*DATA_W +: DATA_W] = clk_q[k];
  end

  always_comb begin
    rd_data = '0;
    case (pkt.addr)
      ADR_CTRL:   rd_data = FW_VERSION;
      ADR_CLK_RB: rd_data = clk_rb_i;
      ADR_STATUS: rd_data = status_i;
      default:    rd_data = '0;
    endcase
    for (int k = 0; k < NUM_CLK; k++) begin
      if (pkt.addr == ADR_CLK_BASE + ADDR_W'(k)) rd_data = clk_q[k];
    end
  end
endmodule

// File: rtl/reply_tx.sv
module reply_tx
  import pktreg_pkg::*;
#(
  parameter int BYTES = PKT_BYTES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [BYTES*BYTE_W-1:0] load_pkt,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [BYTE_W-1:0]       out_byte
);
  localparam int LW = $clog2(BYTES + 1);

  logic [BYTES*BYTE_W-1:0] sh;
  logic [LW-1:0]           left;

  assign out_valid = (left != '0);
  assign out_byte  = sh[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      sh   <= '0;
    end else if (load && !out_valid) begin
      sh   <= load_pkt;
      left <= LW'(BYTES);
    end else if (out_valid && out_ready) begin
      sh   <= sh >> BYTE_W;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/pkt_regbank.sv
module pkt_regbank
  import pktreg_pkg::*;
#(
  parameter int                NUM_CLK    = 25,
  parameter logic [DATA_W-1:0] FW_VERSION = 16'h0107
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      abort_i,
  input  logic                      rx_valid_i,
  output logic                      rx_ready_o,
  input  logic [BYTE_W-1:0]         rx_byte_i,
  output logic                      tx_valid_o,
  input  logic                      tx_ready_i,
  output logic [BYTE_W-1:0]         tx_byte_o,
  input  logic [DATA_W-1:0]         clk_rb_i,
  input  logic [DATA_W-1:0]         status_i,
  output logic [DATA_W-1:0]         board_ctrl_o,
  output logic [NUM_CLK*DATA_W-1:0] clk_regs_o
);
  logic              pkt_vld;
  pkt_t              pkt_q;
  logic [CMD_W-1:0]  pkt_cmd;
  logic [ADDR_W-1:0] pkt_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_go;
  pkt_t              reply;

  assign pkt_cmd    = pkt_q.cmd;
  assign pkt_addr   = pkt_q.addr;
  assign rx_ready_o = !tx_valid_o && !pkt_vld;
  assign rd_go      = pkt_vld && (pkt_cmd == CMD_READ);

  always_comb begin
    reply.cmd  = pkt_cmd;
    reply.addr = pkt_addr;
    reply.data = rd_data;
  end

  pkt_collector #(.BYTES(PKT_BYTES)) u_col (
    .clk      (clk),
    .rst      (rst),
    .abort_i  (abort_i),
    .in_valid (rx_valid_i),
    .in_ready (rx_ready_o),
    .in_byte  (rx_byte_i),
    .pkt_vld  (pkt_vld),
    .pkt      (pkt_q)
  );

  reg_bank #(.NUM_CLK(NUM_CLK), .FW_VERSION(FW_VERSION)) u_bank (
    .clk          (clk),
    .rst          (rst),
    .pkt_vld      (pkt_vld),
    .pkt          (pkt_q),
    .clk_rb_i     (clk_rb_i),
    .status_i     (status_i),
    .board_ctrl_o (board_ctrl_o),
    .clk_regs_o   (clk_regs_o),
    .rd_data      (rd_data)
  );

  reply_tx #(.BYTES(PKT_BYTES)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (rd_go),
    .load_pkt  (reply),
    .out_ready (tx_ready_i),
    .out_valid (tx_valid_o),
    .out_byte  (tx_byte_o)
  );
endmodule

// File: rtl/pkt_regbank_chk.sv
module pkt_regbank_chk
  import pktreg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              abort_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [BYTE_W-1:0] tx_byte_o,
  input logic [DATA_W-1:0] board_ctrl_o,
  input logic              pkt_vld,
  input logic [CMD_W-1:0]  pkt_cmd,
  input logic [ADDR_W-1:0] pkt_addr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!tx_valid_o && rx_ready_o && board_ctrl_o == '0));

  // R3
  ctrl_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(board_ctrl_o) |-> ($past(pkt_vld) && $past(pkt_cmd) == CMD_WRITE
                                && $past(pkt_addr) == ADR_CTRL));

  // R5
  read_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && pkt_cmd == CMD_READ) |=> tx_valid_o);

  // R8
  no_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && pkt_cmd != CMD_READ) |=> !tx_valid_o);

  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !pkt_vld);

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  // R10
  rx_block_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> !rx_ready_o);
endmodule

bind pkt_regbank pkt_regbank_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .abort_i      (abort_i),
  .rx_ready_o   (rx_ready_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .tx_byte_o    (tx_byte_o),
  .board_ctrl_o (board_ctrl_o),
  .pkt_vld      (pkt_vld),
  .pkt_cmd      (pkt_cmd),
  .pkt_addr     (pkt_addr)
);

// File: tb/sim_pkt_regbank.sv
`timescale 1ns/1ps
module sim_pkt_regbank;
  localparam int          NCLK = 25;
  localparam logic [15:0] FW   = 16'h0107;
  localparam logic [15:0] CRB  = 16'h5A3C;
  localparam logic [15:0] STA  = 16'hC0DE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abort_i = 1'b0;
  logic rx_valid_i = 1'b0;
  logic rx_ready_o;
  logic [7:0] rx_byte_i = '0;
  logic tx_valid_o;
  logic tx_ready_i = 1'b1;
  logic [7:0] tx_byte_o;
  logic [15:0] board_ctrl_o;
  logic [NCLK*16-1:0] clk_regs_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] bc_m = '0;
  logic [NCLK*16-1:0] clk_m = '0;

  always #5 clk = ~clk;

  pkt_regbank #(.NUM_CLK(NCLK), .FW_VERSION(FW)) u0 (
    .clk(clk), .rst(rst), .abort_i(abort_i),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_byte_i(rx_byte_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_byte_o(tx_byte_o),
    .clk_rb_i(CRB), .status_i(STA),
    .board_ctrl_o(board_ctrl_o), .clk_regs_o(clk_regs_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!rx_ready_o) @(negedge clk);
    rx_valid_i = 1'b1;
    rx_byte_i  = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  // R2: data low byte, data high byte, address low byte, {cmd, address high}
  task automatic send_pkt(input logic [3:0] c, input logic [11:0] a, input logic [15:0] d);
    send_byte(d[7:0]);
    send_byte(d[15:8]);
    send_byte(a[7:0]);
    send_byte({c, a[11:8]});
  endtask

  task automatic recv_reply(output logic [31:0] p, output int got);
    tx_ready_i = 1'b1;
    got = 0;
    p = '0;
    for (int t = 0; t < 40 && got < 4; t++) begin
      if (tx_valid_o) begin
        p[got*8 +: 8] = tx_byte_o;
        got++;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int a);
    if (a == 1) return FW;
    if (a == 2) return CRB;
    if (a == 3) return STA;
    if (a >= 16 && a < 16 + NCLK) return clk_m[(a-16)*16 +: 16];
    return 16'h0000;
  endfunction

  function automatic int sweep_addr(input int i);
    if (i < 48) return i;
    if (i == 48) return 12'h110;
    if (i == 49) return 12'hFFF;
    return 12'h810;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rp;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", {16'h0, board_ctrl_o}, 32'h0);
    chk("R1 clk", {31'h0, clk_regs_o == '0}, 32'h1);
    chk("R1 tx_valid", {31'h0, tx_valid_o}, 32'h0);
    chk("R1 rx_ready", {31'h0, rx_ready_o}, 32'h1);

    // write sweep: R2 R3 R4 R7
    for (int i = 0; i < 51; i++) begin
      int a;
      logic [15:0] v;
      a = sweep_addr(i);
      v = 16'(a * 16'h1357) ^ 16'hA5C3;
      send_pkt(4'h1, 12'(a), v);
      @(negedge clk);
      if (a == 1) bc_m = v;
      else if (a >= 16 && a < 16 + NCLK) clk_m[(a-16)*16 +: 16] = v;
      chk((a == 1) ? "R2 R3 ctrl" : "R7 ctrl", {16'h0, board_ctrl_o}, {16'h0, bc_m});
      chk((a >= 16 && a < 16 + NCLK) ? "R2 R4 clk" : "R7 clk",
          {31'h0, clk_regs_o == clk_m}, 32'h1);
      chk("R5 no reply to write", {31'h0, tx_valid_o}, 32'h0);
    end

    // read sweep: R5 R6 R7
    for (int i = 0; i < 51; i++) begin
      int a;
      a = sweep_addr(i);
      send_pkt(4'h2, 12'(a), 16'hFFFF ^ 16'(a));
      recv_reply(rp, n);
      chk("R5 reply bytes", n, 4);
      chk((a == 1 || a == 2 || a == 3 || (a >= 16 && a < 16 + NCLK)) ? "R5 R6 read" : "R7 read",
          rp, {4'h2, 12'(a), exp_rd(a)});
    end

    // R8 other commands
    for (int c = 0; c < 16; c++) begin
      if (c == 1 || c == 2) continue;
      send_pkt(4'(c), 12'h001, 16'hDEAD);
      for (int t = 0; t < 8; t++) begin
        chk("R8 no reply", {31'h0, tx_valid_o}, 32'h0);
        @(negedge clk);
      end
      chk("R8 ctrl kept", {16'h0, board_ctrl_o}, {16'h0, bc_m});
    end
    send_pkt(4'h9, 12'h010, 16'hBEEF);
    repeat (2) @(negedge clk);
    chk("R8 clk kept", {31'h0, clk_regs_o == clk_m}, 32'h1);

    // R9 abort after two bytes
    send_byte(8'h11);
    send_byte(8'h22);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    send_pkt(4'h1, 12'h001, 16'h1234);
    @(negedge clk);
    bc_m = 16'h1234;
    chk("R9 abort 2B", {16'h0, board_ctrl_o}, 32'h1234);

    // R9 abort after three bytes, byte offered during abort
    send_byte(8'h33);
    send_byte(8'h44);
    send_byte(8'h55);
    abort_i = 1'b1;
    rx_valid_i = 1'b1;
    rx_byte_i = 8'h66;
    @(negedge clk);
    abort_i = 1'b0;
    rx_valid_i = 1'b0;
    send_pkt(4'h1, 12'h028, 16'h0F0F);
    @(negedge clk);
    clk_m[24*16 +: 16] = 16'h0F0F;
    chk("R9 abort 3B", {31'h0, clk_regs_o == clk_m}, 32'h1);
    chk("R9 ctrl kept", {16'h0, board_ctrl_o}, {16'h0, bc_m});

    // R10 stalled reply with inbound bytes offered
    tx_ready_i = 1'b0;
    send_pkt(4'h2, 12'h010, 16'h0000);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_byte_i = 8'h77;
    for (int t = 0; t < 5; t++) begin
      chk("R10 hold valid", {31'h0, tx_valid_o}, 32'h1);
      chk("R10 hold byte", {24'h0, tx_byte_o}, {24'h0, clk_m[7:0]});
      chk("R10 rx blocked", {31'h0, rx_ready_o}, 32'h0);
      @(negedge clk);
    end
    rx_valid_i = 1'b0;
    recv_reply(rp, n);
    chk("R10 reply after stall", rp, {4'h2, 12'h010, clk_m[15:0]});
    send_pkt(4'h1, 12'h001, 16'h4321);
    @(negedge clk);
    chk("R10 alignment kept", {16'h0, board_ctrl_o}, 32'h4321);

    // R1 reset again clears state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctrl after reset", {16'h0, board_ctrl_o}, 32'h0);
    chk("R1 clk after reset", {31'h0, clk_regs_o == '0}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule